// File: doc/BRIEF.md
# Split Instruction/Data Request Dispatcher

This block sits between the processor's request queue and a pair of set-associative level-one tag arrays, one for instructions and one for data. For the request at the head of the queue it raises exactly one event per cycle for the coherence controller behind it. That event is one of three things:

- the request itself, as a load, fetch or store;
- a replacement of the same line when that line is held in the opposite cache;
- a replacement of the least recently used line when the target set has no free way.

The block keeps the two caches exclusive. A line never lives in both caches, so a fetch to a line held by the data cache first evicts it from there, and the reverse holds for data accesses.

Requests arrive on a valid/ready handshake. The head request is consumed only when the event raised for it carries its own address and is accepted. When a replacement was raised, the request stays at the head and is retried once the line has been freed. An outside controller signals when the requested line is in a transient state. The dispatcher then asks for the request to be recycled instead of raising an event.

The dispatcher owns the tag, valid and recency state. An accepted fill allocates the line, an accepted hit refreshes its recency, and an accepted replacement invalidates the line.

Top module: `splitReqDispatcher`

## Requirements
- R1: Request type codes map to event kinds on `evtKind`:
  - code 0 (load) gives 0 (load);
  - code 1 (fetch) gives 1 (fetch);
  - codes 2 (store) and 3 (atomic) both give 2 (store);
  - replacement is kind 3.
  Fetches target the instruction cache (`evtCache`=1) and all other requests target the data cache (`evtCache`=0).
- R2: A request with a type code of 4 to 7 raises `badType`, raises no event and is consumed (`reqReady`=1).
- R3: When the requested line hits in its home cache, or misses with a free way in its set, the request's own event is raised for its own address. A miss fills the lowest-numbered free way.
- R4: When the line misses its home cache and the set (address bits [1:0] by default) is full, a replacement is raised in the home cache for the victim line's address. The request is not consumed.
- R5: The victim is the line in the set whose last accepted access (fill or hit) is the oldest.
- R6: When the requested line is held in the opposite cache, a replacement of that same address in that opposite cache is raised first, and the request is not consumed. No line is ever present in both caches.
- R7: While `lineBusy` is high with a valid request of known type, `recycle` is high, no event is raised, the request is not consumed and no tag state changes.
- R8: The request is consumed only in the cycle where a non-replacement event for its address is accepted (`evtValid` and `evtReady`). While `evtReady` is low, no state changes and the same event is offered again.
- R9: After reset every line of both caches is invalid. With `reqValid` low, no event, consume, recycle or error output is raised.
- R10: An accepted replacement removes the line, so a retry of the request then proceeds as a miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Head request present |
| reqType | input | 3 | Request type code (0 load, 1 fetch, 2 store, 3 atomic) |
| reqAddr | input | ADDR_W | Line address of the request |
| lineBusy | input | 1 | Requested line is in a transient coherence state |
| reqReady | output | 1 | Head request consumed this cycle |
| recycle | output | 1 | Head request must be rotated to the back of the queue |
| badType | output | 1 | Head request carries an unknown type code |
| evtValid | output | 1 | Event offered to the coherence controller |
| evtReady | input | 1 | Coherence controller accepts the event |
| evtKind | output | 2 | Event kind (0 load, 1 fetch, 2 store, 3 replace) |
| evtCache | output | 1 | Cache the event targets (1 instruction, 0 data) |
| evtAddr | output | ADDR_W | Line address the event applies to |

## Verification
Some properties are checked by assertions on every cycle:
- the lookup never finds the requested line in both caches;
- a consumed request always coincides with an accepted event for its own address;
- recycling never coincides with an event;
- a victim replacement stays in the request's set and is raised only when that set is full;
- fills and evictions land on a way in the expected valid state.

Other behaviour only the bench's scenarios can show:
- that the recency order picks the right victim after a series of hits;
- that a cross-cache line is evicted and then refetched into the other cache;
- that stalled or recycled requests leave the tag state untouched.

These are shown by comparing every cycle against a model that tracks last-use times.

// File: rtl/dispPkg.sv
package dispPkg;

  typedef enum logic [1:0] {
    EV_LOAD    = 2'd0,
    EV_FETCH   = 2'd1,
    EV_STORE   = 2'd2,
    EV_REPLACE = 2'd3
  } evKind_t;

  localparam logic [2:0] RQ_LD     = 3'd0;
  localparam logic [2:0] RQ_IFETCH = 3'd1;
  localparam logic [2:0] RQ_ST     = 3'd2;
  localparam logic [2:0] RQ_ATOMIC = 3'd3;

  localparam int CACHE_D = 0;
  localparam int CACHE_I = 1;

  // strobes from the control to one tag array
  typedef struct packed {
    logic touch;
    logic alloc;
    logic evict;
  } tagStrobe_t;

endpackage

// File: rtl/dispTagArray.sv
module dispTagArray
  import dispPkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic [ADDR_W-1:0] lookAddr,
  input  tagStrobe_t        strobe,
  input  logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] updWay,
  output logic              hit,
  output logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] hitWay,
  output logic              hasFree,
  output logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] freeWay,
  output logic [(WAYS>1 ? $clog2(WAYS) : 1)-1:0] victimWay,
  output logic [ADDR_W-1:0] victimAddr
);

  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;
  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;
  localparam int TAG_W = ADDR_W - SET_W;
  localparam logic [WAY_W-1:0] AGE_OLDEST = WAY_W'(WAYS - 1);

  logic [TAG_W-1:0] tags  [SETS][WAYS];
  logic [WAY_W-1:0] age   [SETS][WAYS];
  logic [WAYS-1:0]  valid [SETS];

  logic [SET_W-1:0] setIdx;
  logic [TAG_W-1:0] tagIn;

  assign setIdx = lookAddr[SET_W-1:0];
  assign tagIn  = lookAddr[ADDR_W-1:SET_W];

  always_comb begin
    hit       = 1'b0;
    hitWay    = '0;
    hasFree   = 1'b0;
    freeWay   = '0;
    victimWay = '0;
    for (int w = WAYS - 1; w >= 0; w--) begin
      if (!valid[setIdx][w]) begin
        hasFree = 1'b1;
        freeWay = WAY_W'(w);
      end
    end
    for (int w = 0; w < WAYS; w++) begin
      if (valid[setIdx][w] && tags[setIdx][w] == tagIn) begin
        hit    = 1'b1;
        hitWay = WAY_W'(w);
      end
      if (age[setIdx][w] == AGE_OLDEST) victimWay = WAY_W'(w);
    end
  end

  assign victimAddr = {tags[setIdx][victimWay], setIdx};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int s = 0; s < SETS; s++) begin
        valid[s] <= '0;
        for (int w = 0; w < WAYS; w++) begin
          tags[s][w] <= '0;
          age[s][w]  <= WAY_W'(w);
        end
      end
    end else begin
      if (strobe.alloc) begin
        tags[setIdx][updWay]  <= tagIn;
        valid[setIdx][updWay] <= 1'b1;
      end
      if (strobe.evict) valid[setIdx][updWay] <= 1'b0;
      if (strobe.touch || strobe.alloc) begin
        for (int w = 0; w < WAYS; w++) begin
          if (WAY_W'(w) == updWay)
            age[setIdx][w] <= '0;
          else if (age[setIdx][w] < age[setIdx][updWay])
            age[setIdx][w] <= age[setIdx][w] + 1'b1;
        end
      end
    end
  end

  // R3: a fill only goes into a free way of a set that misses
  a_r3_alloc_free: assert property (@(posedge clk) disable iff (!rstN)
    strobe.alloc |-> (hasFree && !hit && freeWay == updWay));

  // R10: an eviction targets a valid way and leaves it invalid
  a_r10_evict_valid: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evict |-> valid[setIdx][updWay]);

  a_r10_evict_clears: assert property (@(posedge clk) disable iff (!rstN)
    strobe.evict |=> !valid[$past(setIdx)][$past(updWay)]);

endmodule

// File: rtl/dispCtrl.sv
module dispCtrl
  import dispPkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              lineBusy,
  input  logic              evtReady,
  input  logic [1:0]        hit,
  input  logic [1:0][(WAYS>1 ? $clog2(WAYS) : 1)-1:0] hitWay,
  input  logic [1:0]        hasFree,
  input  logic [1:0][(WAYS>1 ? $clog2(WAYS) : 1)-1:0] freeWay,
  input  logic [1:0][(WAYS>1 ? $clog2(WAYS) : 1)-1:0] victimWay,
  input  logic [1:0][ADDR_W-1:0] victimAddr,
  output tagStrobe_t [1:0]  strobe,
  output logic [1:0][(WAYS>1 ? $clog2(WAYS) : 1)-1:0] updWay,
  output logic              reqReady,
  output logic              recycle,
  output logic              badType,
  output logic              evtValid,
  output evKind_t           evtKind,
  output logic              evtCache,
  output logic [ADDR_W-1:0] evtAddr
);

  localparam int SET_W = (SETS > 1) ? $clog2(SETS) : 1;

  evKind_t reqKind;
  logic    knownType;
  logic    home;
  logic    other;
  logic    fire;

  always_comb begin
    knownType = 1'b1;
    reqKind   = EV_LOAD;
    case (reqType)
      RQ_LD:             reqKind = EV_LOAD;
      RQ_IFETCH:         reqKind = EV_FETCH;
      RQ_ST, RQ_ATOMIC:  reqKind = EV_STORE;
      default:           knownType = 1'b0;
    endcase
  end

  assign home  = (reqType == RQ_IFETCH);
  assign other = ~home;
  assign fire  = evtValid && evtReady;

  always_comb begin
    evtValid = 1'b0;
    evtKind  = EV_LOAD;
    evtCache = home;
    evtAddr  = reqAddr;
    reqReady = 1'b0;
    recycle  = 1'b0;
    badType  = 1'b0;
    strobe   = '0;
    updWay   = '0;
    if (reqValid) begin
      if (!knownType) begin
        badType  = 1'b1;
        reqReady = 1'b1;
      end else if (lineBusy) begin
        recycle = 1'b1;
      end else begin
        evtValid = 1'b1;
        if (hit[other]) begin
          evtKind              = EV_REPLACE;
          evtCache             = other;
          updWay[other]        = hitWay[other];
          strobe[other].evict  = evtReady;
        end else if (hit[home]) begin
          evtKind             = reqKind;
          updWay[home]        = hitWay[home];
          strobe[home].touch  = evtReady;
          reqReady            = evtReady;
        end else if (hasFree[home]) begin
          evtKind             = reqKind;
          updWay[home]        = freeWay[home];
          strobe[home].alloc  = evtReady;
          reqReady            = evtReady;
        end else begin
          evtKind             = EV_REPLACE;
          evtAddr             = victimAddr[home];
          updWay[home]        = victimWay[home];
          strobe[home].evict  = evtReady;
        end
      end
    end
  end

  // R6: the requested line is never found in both caches
  a_r6_exclusive: assert property (@(posedge clk) disable iff (!rstN)
    !(hit[0] && hit[1]));

  // R8: consuming a known request needs an accepted event for its own address
  a_r8_consume_own: assert property (@(posedge clk) disable iff (!rstN)
    (reqReady && !badType) |-> (fire && evtAddr == reqAddr && evtKind != EV_REPLACE));

  // R7: recycling raises no event and consumes nothing
  a_r7_recycle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    recycle |-> (!evtValid && !reqReady && strobe == '0));

  // R4: a victim replacement stays in the request's set, which must be full
  a_r4_victim_set: assert property (@(posedge clk) disable iff (!rstN)
    (evtValid && evtKind == EV_REPLACE && evtAddr != reqAddr) |->
      (evtAddr[SET_W-1:0] == reqAddr[SET_W-1:0] && !hasFree[evtCache]));

endmodule

// File: rtl/splitReqDispatcher.sv
module splitReqDispatcher
  import dispPkg::*;
#(
  parameter int SETS   = 4,
  parameter int WAYS   = 2,
  parameter int ADDR_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              reqValid,
  input  logic [2:0]        reqType,
  input  logic [ADDR_W-1:0] reqAddr,
  input  logic              lineBusy,
  output logic              reqReady,
  output logic              recycle,
  output logic              badType,
  output logic              evtValid,
  input  logic              evtReady,
  output logic [1:0]        evtKind,
  output logic              evtCache,
  output logic [ADDR_W-1:0] evtAddr
);

  localparam int WAY_W = (WAYS > 1) ? $clog2(WAYS) : 1;

  logic [1:0]                   hit;
  logic [1:0][WAY_W-1:0]        hitWay;
  logic [1:0]                   hasFree;
  logic [1:0][WAY_W-1:0]        freeWay;
  logic [1:0][WAY_W-1:0]        victimWay;
  logic [1:0][ADDR_W-1:0]       victimAddr;
  tagStrobe_t [1:0]             strobe;
  logic [1:0][WAY_W-1:0]        updWay;
  evKind_t                      kindOut;

  for (genvar c = 0; c < 2; c++) begin : g_cache
    dispTagArray #(
      .SETS   (SETS),
      .WAYS   (WAYS),
      .ADDR_W (ADDR_W)
    ) u_arr (
      .clk        (clk),
      .rstN       (rstN),
      .lookAddr   (reqAddr),
      .strobe     (strobe[c]),
      .updWay     (updWay[c]),
      .hit        (hit[c]),
      .hitWay     (hitWay[c]),
      .hasFree    (hasFree[c]),
      .freeWay    (freeWay[c]),
      .victimWay  (victimWay[c]),
      .victimAddr (victimAddr[c])
    );
  end

  dispCtrl #(
    .SETS   (SETS),
    .WAYS   (WAYS),
    .ADDR_W (ADDR_W)
  ) u_ctrl (
    .clk        (clk),
    .rstN       (rstN),
    .reqValid   (reqValid),
    .reqType    (reqType),
    .reqAddr    (reqAddr),
    .lineBusy   (lineBusy),
    .evtReady   (evtReady),
    .hit        (hit),
    .hitWay     (hitWay),
    .hasFree    (hasFree),
    .freeWay    (freeWay),
    .victimWay  (victimWay),
    .victimAddr (victimAddr),
    .strobe     (strobe),
    .updWay     (updWay),
    .reqReady   (reqReady),
    .recycle    (recycle),
    .badType    (badType),
    .evtValid   (evtValid),
    .evtKind    (kindOut),
    .evtCache   (evtCache),
    .evtAddr    (evtAddr)
  );

  assign evtKind = kindOut;

endmodule

// File: tb/splitReqDispatcher_tb.sv
module splitReqDispatcher_tb;

  localparam int SETS = 4;
  localparam int WAYS = 2;

  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       reqValid = 1'b0;
  logic [2:0] reqType = '0;
  logic [7:0] reqAddr = '0;
  logic       lineBusy = 1'b0;
  logic       evtReady = 1'b0;
  logic       reqReady, recycle, badType, evtValid, evtCache;
  logic [1:0] evtKind;
  logic [7:0] evtAddr;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  splitReqDispatcher u_dut (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqType(reqType),
    .reqAddr(reqAddr), .lineBusy(lineBusy), .reqReady(reqReady),
    .recycle(recycle), .badType(badType), .evtValid(evtValid),
    .evtReady(evtReady), .evtKind(evtKind), .evtCache(evtCache),
    .evtAddr(evtAddr)
  );

  always #5 clk = ~clk;

  // model: cache 0 data, 1 instruction; full line address and last-use time
  logic [7:0] mLine  [2][SETS][WAYS];
  bit         mVal   [2][SETS][WAYS];
  int         mStamp [2][SETS][WAYS];
  int         now = 1;

  logic       eReady, eRecycle, eBad, eValid, eCache;
  logic [1:0] eKind;
  logic [7:0] eAddr;
  int         uOp, uCache, uWay;
  string      eTag;

  task automatic modelEval(input logic v, input logic [2:0] t, input logic [7:0] a,
                           input logic b, input logic rdy);
    int s, home, other, hw, ow, fw, vw;
    bit hh, oh, hf, known;
    logic [1:0] k;
    eReady = 0; eRecycle = 0; eBad = 0; eValid = 0; eCache = 0; eKind = 0; eAddr = a;
    uOp = 0; uCache = 0; uWay = 0; eTag = "R9";
    if (!v) return;
    known = 1; k = 0;
    case (t)
      3'd0: k = 2'd0;
      3'd1: k = 2'd1;
      3'd2, 3'd3: k = 2'd2;
      default: known = 0;
    endcase
    if (!known) begin eBad = 1; eReady = 1; eTag = "R2"; return; end
    if (b) begin eRecycle = 1; eTag = "R7"; return; end
    s = int'(a[1:0]);
    home = (t == 3'd1) ? 1 : 0;
    other = 1 - home;
    hh = 0; oh = 0; hf = 0; hw = 0; ow = 0; fw = 0; vw = 0;
    for (int w = 0; w < WAYS; w++) begin
      if (mVal[home][s][w] && mLine[home][s][w] == a) begin hh = 1; hw = w; end
      if (mVal[other][s][w] && mLine[other][s][w] == a) begin oh = 1; ow = w; end
    end
    for (int w = WAYS - 1; w >= 0; w--) if (!mVal[home][s][w]) begin hf = 1; fw = w; end
    for (int w = 1; w < WAYS; w++) if (mStamp[home][s][w] < mStamp[home][s][vw]) vw = w;
    eValid = 1;
    if (oh) begin
      eKind = 2'd3; eCache = other[0]; uOp = 3; uCache = other; uWay = ow; eTag = "R6";
    end else if (hh) begin
      eKind = k; eCache = home[0]; eReady = rdy; uOp = 1; uCache = home; uWay = hw; eTag = "R3";
    end else if (hf) begin
      eKind = k; eCache = home[0]; eReady = rdy; uOp = 2; uCache = home; uWay = fw; eTag = "R1";
    end else begin
      eKind = 2'd3; eCache = home[0]; eAddr = mLine[home][s][vw];
      uOp = 3; uCache = home; uWay = vw; eTag = "R4";
    end
    if (!rdy) begin uOp = 0; eTag = "R8"; end
  endtask

  task automatic modelApply(input logic [7:0] a);
    int s;
    s = int'(a[1:0]);
    case (uOp)
      1: mStamp[uCache][s][uWay] = now;
      2: begin
        mVal[uCache][s][uWay] = 1; mLine[uCache][s][uWay] = a; mStamp[uCache][s][uWay] = now;
      end
      3: mVal[uCache][s][uWay] = 0;
      default: ;
    endcase
    now++;
  endtask

  task automatic step(input logic v, input logic [2:0] t, input logic [7:0] a,
                      input logic b, input logic rdy, input string tag);
    bit bad;
    @(negedge clk);
    reqValid = v; reqType = t; reqAddr = a; lineBusy = b; evtReady = rdy;
    #2;
    modelEval(v, t, a, b, rdy);
    bad = (reqReady !== eReady) || (recycle !== eRecycle) || (badType !== eBad) ||
          (evtValid !== eValid);
    if (eValid && !bad)
      bad = (evtKind !== eKind) || (evtCache !== eCache) || (evtAddr !== eAddr);
    checks++;
    if (bad) begin
      fails++;
      $display("FAIL %s (%s): got rdy=%b rc=%b bad=%b v=%b k=%0d c=%b a=%h exp rdy=%b rc=%b bad=%b v=%b k=%0d c=%b a=%h",
               tag, eTag, reqReady, recycle, badType, evtValid, evtKind, evtCache, evtAddr,
               eReady, eRecycle, eBad, eValid, eKind, eCache, eAddr);
    end
    modelApply(a);
  endtask

  initial begin
    for (int c = 0; c < 2; c++)
      for (int s = 0; s < SETS; s++)
        for (int w = 0; w < WAYS; w++) begin
          mVal[c][s][w] = 0; mLine[c][s][w] = '0; mStamp[c][s][w] = 0;
        end
    void'($urandom(32'd2024));
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    step(0, 3'd0, 8'h00, 0, 1, "R9 idle after reset");
    step(1, 3'd0, 8'h10, 0, 1, "R1 load fills data cache");
    step(1, 3'd1, 8'h21, 0, 1, "R1 fetch fills instruction cache");
    step(1, 3'd2, 8'h32, 0, 1, "R1 store");
    step(1, 3'd3, 8'h43, 0, 1, "R1 atomic maps to store");
    step(1, 3'd0, 8'h10, 0, 1, "R3 load hit");
    step(1, 3'd1, 8'h10, 0, 1, "R6 fetch of data-cache line replaces it");
    step(1, 3'd1, 8'h10, 0, 1, "R10 retry after eviction fetches");
    step(1, 3'd0, 8'h21, 0, 1, "R6 load of instruction line replaces it");
    step(1, 3'd0, 8'h21, 0, 1, "R10 retry load");
    step(1, 3'd0, 8'h52, 0, 1, "R3 second way of set 2");
    step(1, 3'd0, 8'h32, 0, 1, "R5 touch older line");
    step(1, 3'd0, 8'h72, 0, 1, "R5 victim is least recent line");
    step(1, 3'd0, 8'h72, 0, 1, "R4 retry fills freed way");
    step(1, 3'd0, 8'h92, 0, 0, "R8 stalled replacement offered");
    step(1, 3'd0, 8'h92, 0, 0, "R8 same event while stalled");
    step(1, 3'd2, 8'h32, 1, 1, "R7 busy line recycles");
    step(1, 3'd2, 8'h32, 0, 1, "R7 state untouched after recycle");
    step(1, 3'd5, 8'h32, 0, 1, "R2 unknown type");
    step(1, 3'd7, 8'h11, 0, 1, "R2 unknown type 7");

    for (int i = 0; i < 3000; i++) begin
      logic v, b, r;
      logic [2:0] t;
      logic [7:0] a;
      v = ($urandom_range(0, 9) != 0);
      b = ($urandom_range(0, 9) == 0);
      r = ($urandom_range(0, 4) != 0);
      t = ($urandom_range(0, 15) == 0) ? 3'($urandom_range(4, 7)) : 3'($urandom_range(0, 3));
      a = 8'($urandom_range(0, 31));
      step(v, t, a, b, r, "random");
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      checks++;
      fails++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

endmodule